// File: doc/BRIEF.md
# Shift-Chain Push-Down Stack

This block is a last-in first-out store of eight words kept in a chain of bidirectional shift stages instead of an addressed memory. Stage 0 is always the top of the stack and drives the output directly. Every accepted operation moves all stages at once. A push moves each word one stage deeper and loads the incoming word into stage 0. A pop moves each word one stage toward the top, and the deepest stage takes zero.

A separate up/down fill counter follows how many words are held and drives the empty and full flags. One select line chooses between push and pop. Nothing moves unless the enable is high.

A push while full is dropped, and so is a pop while empty. The word being popped is the `top_q` value seen in the cycle in which the pop is applied. The data width and the depth are parameters, with defaults of 8 bits and 8 entries.

Top module: `shift_lifo_stack`

## Requirements
- R1: While `rst` is high at a clock edge (synchronous, active high), the stack becomes empty: after that edge `empty`=1, `full`=0 and `top_q`=0, and `rst` overrides any operation requested in that cycle.
- R2: With `en`=1, `push_n_pop`=1 and `full`=0 at an edge, `top_q` shows `din` after that edge and each older word moves one stage deeper.
- R3: With `en`=1, `push_n_pop`=0 and `empty`=0 at an edge, the popped word is the `top_q` value before that edge, and after it `top_q` shows the word that was second from the top.
- R4: With `en`=0, no stage and no flag changes, whatever the values of `push_n_pop` and `din`.
- R5: `empty` is 1 exactly when no words are held, and `full` is 1 exactly when DEPTH words are held. Both flags update on the same edge as the operation that changes the fill level, and they are never 1 together.
- R6: A push while `full`=1 is ignored. The stored words, `top_q` and the flags do not change.
- R7: A pop while `empty`=1 is ignored. `top_q` stays 0 and `empty` stays 1.
- R8: On a pop the deepest stage loads zero, so `top_q` reads 0 whenever `empty`=1.
- R9: Pushing DEPTH words and then popping DEPTH times returns them in exactly reverse order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, empties the stack |
| en | input | 1 | Operation enable; no shift occurs while low |
| push_n_pop | input | 1 | 1 selects push, 0 selects pop |
| din | input | W | Word to push |
| top_q | output | W | Current top-of-stack word (stage 0) |
| empty | output | 1 | No words held |
| full | output | 1 | DEPTH words held |

## Verification
Since stage 0 is the output, a bad shift or mux choice in any stage shows on `top_q` as soon as pops bring that stage to the top. The effect is immediate for stage 0 and at most DEPTH pops later for the deepest stage. A fill counter that drifts from the true occupancy shows up as an early or late `empty` or `full`, or as a non-zero `top_q` while `empty` is high. A counter that drifts also lets a push at full destroy the deepest word, or lets a pop at empty take effect. The bench compares the outputs against a queue model after every edge. It drives runs that reach both boundaries, so a stage that holds stale data surfaces within one fill-and-drain cycle.

// File: rtl/lifo_pkg.sv
package lifo_pkg;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2
  } stk_op_t;

  // Resolve the request into an operation; boundary requests become holds.
  function automatic stk_op_t decode_op(input logic en,
                                        input logic push_sel,
                                        input logic is_full,
                                        input logic is_empty);
    stk_op_t r;
    r = OP_HOLD;
    if (en) begin
      if (push_sel && !is_full)       r = OP_PUSH;
      else if (!push_sel && !is_empty) r = OP_POP;
    end
    return r;
  endfunction

endpackage

// File: rtl/lifo_stage.sv
module lifo_stage #(
  parameter int W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  lifo_pkg::stk_op_t     op,
  input  logic [W-1:0]          from_up,
  input  logic [W-1:0]          from_dn,
  output logic [W-1:0]          q
);
  import lifo_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      case (op)
        OP_PUSH: q <= from_up;
        OP_POP:  q <= from_dn;
        default: q <= q;
      endcase
    end
  end

  // R4
  stage_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_HOLD) |=> $stable(q));

  // R2
  stage_push_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_PUSH) |=> (q == $past(from_up)));

  // R3
  stage_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_POP) |=> (q == $past(from_dn)));

endmodule

// File: rtl/lifo_fill_ctr.sv
module lifo_fill_ctr #(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  lifo_pkg::stk_op_t op,
  output logic [CW-1:0]     fill,
  output logic              is_empty,
  output logic              is_full
);
  import lifo_pkg::*;

  localparam logic [CW-1:0] LAST = CW'(DEPTH);

  function automatic logic [CW-1:0] fill_next(input logic [CW-1:0] cur,
                                              input stk_op_t o);
    case (o)
      OP_PUSH: return cur + 1'b1;
      OP_POP:  return cur - 1'b1;
      default: return cur;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) fill <= '0;
    else     fill <= fill_next(fill, op);
  end

  assign is_empty = (fill == '0);
  assign is_full  = (fill == LAST);

  // R5
  fill_range_chk: assert property (@(posedge clk) disable iff (rst)
    fill <= LAST);

  // R5
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(is_empty && is_full));

  // R2
  fill_up_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_PUSH) |=> (fill == $past(fill) + 1'b1));

  // R3
  fill_down_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_POP) |=> (fill == $past(fill) - 1'b1));

endmodule

// File: rtl/shift_lifo_stack.sv
module shift_lifo_stack #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         push_n_pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top_q,
  output logic         empty,
  output logic         full
);
  import lifo_pkg::*;

  localparam int CW = $clog2(DEPTH + 1);

  stk_op_t       op;
  logic [CW-1:0] fill;
  logic          is_empty, is_full;

  // Named events for the checks
  logic push_ok, pop_ok, push_drop, pop_drop;

  logic [W-1:0] chain [DEPTH];
  logic [W-1:0] up_v  [DEPTH];
  logic [W-1:0] dn_v  [DEPTH];

  assign op        = decode_op(en, push_n_pop, is_full, is_empty);
  assign push_ok   = (op == OP_PUSH);
  assign pop_ok    = (op == OP_POP);
  assign push_drop = en &&  push_n_pop && is_full;
  assign pop_drop  = en && !push_n_pop && is_empty;

  lifo_fill_ctr #(.DEPTH(DEPTH), .CW(CW)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .fill     (fill),
    .is_empty (is_empty),
    .is_full  (is_full)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_top
      assign up_v[i] = din;
    end else begin : g_mid_up
      assign up_v[i] = chain[i-1];
    end
    if (i == DEPTH - 1) begin : g_deep
      assign dn_v[i] = '0;
    end else begin : g_mid_dn
      assign dn_v[i] = chain[i+1];
    end

    lifo_stage #(.W(W)) u_stage (
      .clk     (clk),
      .rst     (rst),
      .op      (op),
      .from_up (up_v[i]),
      .from_dn (dn_v[i]),
      .q       (chain[i])
    );
  end

  assign top_q = chain[0];
  assign empty = is_empty;
  assign full  = is_full;

  // R2
  push_top_chk: assert property (@(posedge clk) disable iff (rst)
    push_ok |=> (top_q == $past(din)));

  // R6
  full_push_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    push_drop |=> (full && $stable(top_q)));

  // R7
  empty_pop_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    pop_drop |=> (empty && $stable(top_q)));

  // R8
  empty_top_zero_chk: assert property (@(posedge clk) disable iff (rst)
    empty |-> (top_q == '0));

  // R8
  deep_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_ok && (fill == CW'(DEPTH))) |=> (chain[DEPTH-1] == '0));

  // R4
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(top_q) && $stable(empty) && $stable(full)));

endmodule

// File: tb/shift_lifo_stack_test.sv
module shift_lifo_stack_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int DEPTH = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en = 1'b0;
  logic         push_n_pop = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] top_q;
  logic         empty, full;

  int checks = 0;
  int fails  = 0;
  int model[$];
  logic [15:0] lfsr = 16'hACE1;

  shift_lifo_stack #(.W(W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .en(en), .push_n_pop(push_n_pop),
    .din(din), .top_q(top_q), .empty(empty), .full(full)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_top();
    return (model.size() > 0) ? model[0] : 0;
  endfunction

  task automatic compare_all(input string req);
    chk({req, " top"},   int'(top_q), exp_top());
    chk({req, " empty"}, int'(empty), (model.size() == 0) ? 1 : 0);
    chk({req, " full"},  int'(full),  (model.size() == DEPTH) ? 1 : 0);
  endtask

  // Inputs set at negedge, model advanced at the edge, outputs compared at next negedge
  task automatic step(input string req, input logic e, input logic p, input int d);
    en = e; push_n_pop = p; din = W'(d);
    @(posedge clk);
    if (e && p && model.size() < DEPTH) model.push_front(d & 8'hFF);
    else if (e && !p && model.size() > 0) void'(model.pop_front());
    @(negedge clk);
    compare_all(req);
  endtask

  task automatic pop_expect(input string req, input int want);
    chk({req, " popped"}, int'(top_q), want);
    step(req, 1'b1, 1'b0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    en = 1'b1; push_n_pop = 1'b1; din = 8'h77;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0; en = 1'b0;
    // R1 reset state, push requested during reset had no effect
    compare_all("R1");

    // R3 example sequence
    step("R2", 1'b1, 1'b1, 45);
    step("R2", 1'b1, 1'b1, 12);
    step("R2", 1'b1, 1'b1, 23);
    pop_expect("R3", 23);
    chk("R3 new top", int'(top_q), 12);

    // R4 enable low with both selects
    step("R4", 1'b0, 1'b1, 99);
    step("R4", 1'b0, 1'b0, 5);
    chk("R4 top kept", int'(top_q), 12);

    // R7 drain then pop while empty
    pop_expect("R3", 12);
    pop_expect("R3", 45);
    chk("R5 empty", int'(empty), 1);
    step("R7", 1'b1, 1'b0, 0);
    chk("R8 top zero", int'(top_q), 0);

    // R9 fill to full, R6 push at full
    for (int i = 0; i < DEPTH; i++) step("R2", 1'b1, 1'b1, 16 * i + 3);
    chk("R5 full", int'(full), 1);
    step("R6", 1'b1, 1'b1, 200);
    chk("R6 top kept", int'(top_q), 16 * (DEPTH - 1) + 3);
    for (int i = DEPTH - 1; i >= 0; i--) pop_expect("R9", 16 * i + 3);
    chk("R8 empty top", int'(top_q), 0);

    // R8 refill after full drain sees no stale words below
    step("R2", 1'b1, 1'b1, 9);
    pop_expect("R8", 9);

    // pseudo-random mix in phases of push bias and pop bias
    for (int n = 0; n < 600; n++) begin
      logic bias;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      bias = ((n / 40) % 2 == 0);
      if (!lfsr[1] && model.size() > 0 && !bias)
        chk("R3 mix popped", int'(top_q), exp_top());
      step("R5 mix", lfsr[0] | lfsr[1] | lfsr[2],
           bias ? (lfsr[4:3] != 2'b00) : (lfsr[4:3] == 2'b00), int'(lfsr[15:8]));
    end

    // R1 reset from a partly filled stack, with a push requested
    step("R2", 1'b1, 1'b1, 61);
    step("R2", 1'b1, 1'b1, 62);
    rst = 1'b1; en = 1'b1; push_n_pop = 1'b1; din = 8'h55;
    @(posedge clk);
    model.delete();
    @(negedge clk);
    rst = 1'b0; en = 1'b0;
    compare_all("R1 mid");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule